// File: doc/BRIEF.md
# Compare and Conditional-Move Execution Slice

This block is one integer execution slice of a processor core. It carries a 32-bit status-flags word and carries out three operations: a compare, which subtracts a second operand from a first and records the outcome only in the flags; a conditional move, which tests a 4-bit condition code against the flags it holds and forwards a source value to a register-file write port only when the condition is true; and a complement-carry, which inverts the carry flag alone.

Operands are up to 64 bits wide, and a 2-bit size code selects the width. The second operand of a compare can come from a register or from an immediate. An immediate is either 8 or 32 bits wide and is sign-extended. An upstream decoder presents one operation per cycle on a single-cycle valid strobe. The slice never applies back-pressure: it accepts the operation in every cycle that `op_valid` is high. Its results, meaning the flags word and a write strobe with data, are registered and appear one clock after the operation is accepted. The downstream register file must therefore take `wr_en`/`wr_data` in the cycle they are shown.

Top module: `cmx_exec_unit`

## Requirements
- R1: While synchronous reset is high, and in the first cycle after it falls, `flags` reads 0x00000002 and `wr_en` is 0.
- R2: A compare (`op_kind`=0) with `op_size`=3 (64 bits) replaces the status flags by the outcome of first minus second. CF (bit 0) is the unsigned borrow. PF (bit 2) is 1 when the low result byte has an even count of ones. AF (bit 4) is a borrow out of bit 3. ZF (bit 6) marks a zero result. SF (bit 7) is the result's top bit. OF (bit 11) is set when the operand signs differ and the result sign differs from the first operand's sign.
- R3: `op_size` codes 0, 1, 2 and 3 select 8, 16, 32 and 64 bits. For each width, both operands are cut to that width, and CF, ZF, SF and OF come from that width's result and top bit. Bits above the width have no effect.
- R4: With `use_imm`=1, the compare takes its second operand from `imm`. When `imm_is8`=1, `imm[7:0]` is sign-extended. When `imm_is8`=0, all 32 bits are sign-extended. `src_b` is then ignored.
- R5: A compare never raises `wr_en`.
- R6: A conditional move (`op_kind`=1) tests `cond` against the flags held before it. The base predicates, indexed by `cond[3:1]`, are: 0 OF, 1 CF, 2 ZF, 3 CF|ZF, 4 SF, 5 PF, 6 SF^OF, 7 ZF|(SF^OF). `cond[0]`=1 inverts the base predicate.
- R7: A conditional move whose condition holds, at size 16, 32 or 64, raises `wr_en` for exactly one cycle, one clock later. At the same time `wr_data` equals `src_b` cut to the size with the upper bits zero.
- R8: A conditional move whose condition fails leaves `wr_en` low. No conditional move changes `flags`.
- R9: A conditional move with `op_size`=0 is ignored: no write and no flag change.
- R10: A complement-carry (`op_kind`=2) inverts bit 0 of `flags` and leaves bits 31:1 unchanged.
- R11: Every flags bit other than 0, 2, 4, 6, 7 and 11 is constant. Bit 1 reads 1 and all the others read 0.
- R12: A cycle with `op_valid`=0, or with `op_kind`=3, leaves `flags` unchanged and `wr_en` low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| op_valid | input | 1 | Operation strobe, one cycle per operation |
| op_kind | input | 2 | 0 compare, 1 conditional move, 2 complement-carry, 3 no-op |
| op_size | input | 2 | 0/1/2/3 = 8/16/32/64-bit operands |
| src_a | input | 64 | First operand of a compare |
| src_b | input | 64 | Second compare operand, or the move source |
| use_imm | input | 1 | Take the compare's second operand from `imm` |
| imm | input | 32 | Immediate value |
| imm_is8 | input | 1 | Immediate is 8 bits wide (else 32) |
| cond | input | 4 | Condition code for the conditional move |
| wr_en | output | 1 | Destination write strobe |
| wr_data | output | 64 | Destination write value, meaningful while `wr_en` is high |
| flags | output | 32 | Status-flags word |

## Verification
The hardest cases to reach are the condition codes that need an unusual flag combination: SF and OF disagreeing, or PF set while ZF is clear. The slice has no port that loads its flags directly, so the only way to set them is through a compare. The bench therefore picks compare operands that produce each required mix: a signed overflow at byte width, an unsigned borrow, an equal pair, and a parity-even non-zero result. After each one it sweeps all sixteen condition codes with conditional moves. The moves do not disturb the flags, so every sweep runs against one fixed flag state.

// File: rtl/cmx_pkg.sv
package cmx_pkg;
  typedef enum logic [1:0] {
    OP_CMP  = 2'd0,
    OP_CMOV = 2'd1,
    OP_CMC  = 2'd2,
    OP_NONE = 2'd3
  } op_kind_e;

  typedef struct packed {
    logic ovf;
    logic sgn;
    logic zro;
    logic aux;
    logic par;
    logic cry;
  } status_t;

  localparam int CF_POS = 0;
  localparam int PF_POS = 2;
  localparam int AF_POS = 4;
  localparam int ZF_POS = 6;
  localparam int SF_POS = 7;
  localparam int OF_POS = 11;

  localparam logic [31:0] FLAGS_INIT = 32'h0000_0002;
  localparam logic [31:0] FLAGS_LIVE = 32'h0000_08D5;
endpackage

// File: rtl/cmx_operand_sel.sv
module cmx_operand_sel #(
  parameter int DATA_W = 64,
  parameter int IMM_W  = 32
) (
  input  logic [1:0]        size,
  input  logic [DATA_W-1:0] reg_val,
  input  logic              use_imm,
  input  logic [IMM_W-1:0]  imm,
  input  logic              imm_is8,
  output logic [DATA_W-1:0] operand,
  output logic [DATA_W-1:0] width_mask
);
  localparam int BYTE_W = 8;

  logic [DATA_W-1:0] imm_short;
  logic [DATA_W-1:0] imm_long;
  int unsigned       width_bits;

  assign imm_short  = {{(DATA_W-BYTE_W){imm[BYTE_W-1]}}, imm[BYTE_W-1:0]};
  assign imm_long   = {{(DATA_W-IMM_W){imm[IMM_W-1]}}, imm};
  assign width_bits = BYTE_W << size;

  always_comb begin
    if (!use_imm)     operand = reg_val;
    else if (imm_is8) operand = imm_short;
    else              operand = imm_long;
  end

  assign width_mask = {DATA_W{1'b1}} >> (DATA_W - width_bits);
endmodule

// File: rtl/cmx_sub_flags.sv
module cmx_sub_flags
  import cmx_pkg::*;
#(
  parameter int DATA_W = 64
) (
  input  logic [1:0]        size,
  input  logic [DATA_W-1:0] lhs,
  input  logic [DATA_W-1:0] rhs,
  input  logic [DATA_W-1:0] width_mask,
  output status_t           st
);
  localparam int IDX_W = $clog2(DATA_W);

  logic [DATA_W-1:0] lhs_m, rhs_m, diff, res;
  logic [IDX_W-1:0]  top;
  logic              s_l, s_r, s_d;

  assign lhs_m = lhs & width_mask;
  assign rhs_m = rhs & width_mask;
  assign diff  = lhs_m - rhs_m;
  assign res   = diff & width_mask;
  assign top   = IDX_W'((8 << size) - 1);
  assign s_l   = lhs_m[top];
  assign s_r   = rhs_m[top];
  assign s_d   = res[top];

  always_comb begin
    st.cry = lhs_m < rhs_m;
    st.par = ~^res[7:0];
    st.aux = lhs_m[4] ^ rhs_m[4] ^ diff[4];
    st.zro = (res == '0);
    st.sgn = s_d;
    st.ovf = (s_l ^ s_r) & (s_l ^ s_d);
  end
endmodule

// File: rtl/cmx_cond_eval.sv
module cmx_cond_eval
  import cmx_pkg::*;
(
  input  logic [3:0]  code,
  input  logic [31:0] flags_now,
  output logic        take
);
  localparam int N_BASE = 8;

  logic [N_BASE-1:0] base;
  logic cf, pf, zf, sf, ov;

  assign cf = flags_now[CF_POS];
  assign pf = flags_now[PF_POS];
  assign zf = flags_now[ZF_POS];
  assign sf = flags_now[SF_POS];
  assign ov = flags_now[OF_POS];

  always_comb begin
    base[0] = ov;
    base[1] = cf;
    base[2] = zf;
    base[3] = cf | zf;
    base[4] = sf;
    base[5] = pf;
    base[6] = sf ^ ov;
    base[7] = zf | (sf ^ ov);
  end

  assign take = base[code[3:1]] ^ code[0];
endmodule

// File: rtl/cmx_exec_unit.sv
module cmx_exec_unit
  import cmx_pkg::*;
#(
  parameter int DATA_W  = 64,
  parameter int IMM_W   = 32,
  parameter int FLAGS_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              op_valid,
  input  logic [1:0]        op_kind,
  input  logic [1:0]        op_size,
  input  logic [DATA_W-1:0] src_a,
  input  logic [DATA_W-1:0] src_b,
  input  logic              use_imm,
  input  logic [IMM_W-1:0]  imm,
  input  logic              imm_is8,
  input  logic [3:0]        cond,
  output logic              wr_en,
  output logic [DATA_W-1:0] wr_data,
  output logic [FLAGS_W-1:0] flags
);
  op_kind_e          kind;
  logic [DATA_W-1:0] rhs, mask;
  status_t           st;
  logic              take;
  logic [FLAGS_W-1:0] cmp_flags;

  assign kind = op_kind_e'(op_kind);

  cmx_operand_sel #(.DATA_W(DATA_W), .IMM_W(IMM_W)) u_opsel (
    .size(op_size), .reg_val(src_b), .use_imm(use_imm), .imm(imm),
    .imm_is8(imm_is8), .operand(rhs), .width_mask(mask)
  );

  cmx_sub_flags #(.DATA_W(DATA_W)) u_sub (
    .size(op_size), .lhs(src_a), .rhs(rhs), .width_mask(mask), .st(st)
  );

  cmx_cond_eval u_cond (
    .code(cond), .flags_now(flags), .take(take)
  );

  always_comb begin
    cmp_flags         = flags;
    cmp_flags[CF_POS] = st.cry;
    cmp_flags[PF_POS] = st.par;
    cmp_flags[AF_POS] = st.aux;
    cmp_flags[ZF_POS] = st.zro;
    cmp_flags[SF_POS] = st.sgn;
    cmp_flags[OF_POS] = st.ovf;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      flags   <= FLAGS_INIT;
      wr_en   <= 1'b0;
      wr_data <= '0;
    end else begin
      wr_en <= 1'b0;
      if (op_valid) begin
        unique case (kind)
          OP_CMP:  flags <= cmp_flags;
          OP_CMOV: begin
            if (op_size != 2'd0 && take) begin
              wr_en   <= 1'b1;
              wr_data <= src_b & mask;
            end
          end
          OP_CMC:  flags[CF_POS] <= ~flags[CF_POS];
          default: ;
        endcase
      end
    end
  end
endmodule

// File: rtl/cmx_exec_checker.sv
module cmx_exec_checker (
  input logic        clk,
  input logic        rst,
  input logic        op_valid,
  input logic [1:0]  op_kind,
  input logic [1:0]  op_size,
  input logic        wr_en,
  input logic [31:0] flags
);
  assert_cmp_no_write_R5: assert property (@(posedge clk) disable iff (rst)
    (op_valid && op_kind == 2'd0) |=> !wr_en);

  assert_wr_origin_R7: assert property (@(posedge clk) disable iff (rst)
    wr_en |-> $past(op_valid && op_kind == 2'd1 && !rst));

  assert_cmov_keeps_flags_R8: assert property (@(posedge clk) disable iff (rst)
    (op_valid && op_kind == 2'd1) |=> $stable(flags));

  assert_byte_cmov_ignored_R9: assert property (@(posedge clk) disable iff (rst)
    (op_valid && op_kind == 2'd1 && op_size == 2'd0) |=> (!wr_en && $stable(flags)));

  assert_cmc_toggle_R10: assert property (@(posedge clk) disable iff (rst)
    (op_valid && op_kind == 2'd2) |=>
      ((flags[0] != $past(flags[0])) && (flags[31:1] == $past(flags[31:1]))));

  assert_reserved_R11: assert property (@(posedge clk) disable iff (rst)
    ((flags & ~32'h0000_08D5) == 32'h0000_0002));

  assert_idle_R12: assert property (@(posedge clk) disable iff (rst)
    (!op_valid || op_kind == 2'd3) |=> (!wr_en && $stable(flags)));
endmodule

bind cmx_exec_unit cmx_exec_checker chk_i (
  .clk(clk), .rst(rst), .op_valid(op_valid), .op_kind(op_kind),
  .op_size(op_size), .wr_en(wr_en), .flags(flags)
);

// File: tb/cmx_exec_unit_tb_top.sv
module cmx_exec_unit_tb_top;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        op_valid = 1'b0;
  logic [1:0]  op_kind = 2'd3;
  logic [1:0]  op_size = 2'd3;
  logic [63:0] src_a = '0;
  logic [63:0] src_b = '0;
  logic        use_imm = 1'b0;
  logic [31:0] imm = '0;
  logic        imm_is8 = 1'b0;
  logic [3:0]  cond = '0;
  logic        wr_en;
  logic [63:0] wr_data;
  logic [31:0] flags;

  int n_chk = 0;
  int n_bad = 0;
  int cyc = 0;
  logic [31:0] exp_flags = 32'h2;

  always #4 clk = ~clk;

  cmx_exec_unit dut_i (
    .clk(clk), .rst(rst), .op_valid(op_valid), .op_kind(op_kind),
    .op_size(op_size), .src_a(src_a), .src_b(src_b), .use_imm(use_imm),
    .imm(imm), .imm_is8(imm_is8), .cond(cond), .wr_en(wr_en),
    .wr_data(wr_data), .flags(flags)
  );

  task automatic finish_run();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  endtask

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 100000) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: actual %0d cycles, expected < 100000", cyc);
      finish_run();
    end
  end

  task automatic check(string req, logic [63:0] act, logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  function automatic logic [63:0] wmask(logic [1:0] sz);
    case (sz)
      2'd0: return 64'h0000_0000_0000_00FF;
      2'd1: return 64'h0000_0000_0000_FFFF;
      2'd2: return 64'h0000_0000_FFFF_FFFF;
      default: return 64'hFFFF_FFFF_FFFF_FFFF;
    endcase
  endfunction

  function automatic logic [31:0] ref_cmp(logic [63:0] a, logic [63:0] b, logic [1:0] sz);
    int w = 8 << sz;
    logic [63:0] m = wmask(sz);
    logic [63:0] am = a & m;
    logic [63:0] bm = b & m;
    logic [63:0] r = (am - bm) & m;
    logic sa = am[w-1];
    logic sb = bm[w-1];
    logic sr = r[w-1];
    logic [31:0] f = 32'h2;
    int ones = 0;
    for (int i = 0; i < 8; i++) ones += r[i];
    f[0]  = am < bm;
    f[2]  = (ones % 2) == 0;
    f[4]  = am[3:0] < bm[3:0];
    f[6]  = (r == 0);
    f[7]  = sr;
    f[11] = (sa != sb) && (sr != sa);
    return f;
  endfunction

  function automatic logic ref_cond(logic [31:0] f, logic [3:0] c);
    logic cf = f[0], pf = f[2], zf = f[6], sf = f[7], ov = f[11];
    case (c)
      4'h0: return ov;          4'h1: return !ov;
      4'h2: return cf;          4'h3: return !cf;
      4'h4: return zf;          4'h5: return !zf;
      4'h6: return cf || zf;    4'h7: return !cf && !zf;
      4'h8: return sf;          4'h9: return !sf;
      4'hA: return pf;          4'hB: return !pf;
      4'hC: return sf != ov;    4'hD: return sf == ov;
      4'hE: return zf || (sf != ov);
      default: return !zf && (sf == ov);
    endcase
  endfunction

  task automatic issue(logic [1:0] k, logic [1:0] sz, logic [63:0] a, logic [63:0] b,
                       logic ui, logic [31:0] iv, logic i8, logic [3:0] c);
    @(negedge clk);
    op_valid = 1'b1; op_kind = k; op_size = sz; src_a = a; src_b = b;
    use_imm = ui; imm = iv; imm_is8 = i8; cond = c;
    @(negedge clk);
    op_valid = 1'b0;
  endtask

  task automatic do_cmp(string req, logic [1:0] sz, logic [63:0] a, logic [63:0] b);
    issue(2'd0, sz, a, b, 1'b0, 32'h0, 1'b0, 4'h0);
    exp_flags = ref_cmp(a, b, sz);
    check(req, flags, exp_flags);
    check("R5 cmp no write", wr_en, 0);
  endtask

  task automatic t_reset();
    check("R1 flags at reset", flags, 32'h2);
    check("R1 wr_en at reset", wr_en, 0);
  endtask

  task automatic t_cmp_basic();
    do_cmp("R2 greater", 2'd3, 64'd10, 64'd3);
    do_cmp("R2 borrow", 2'd3, 64'd1, 64'd2);
    do_cmp("R2 equal", 2'd3, 64'h1234, 64'h1234);
    do_cmp("R2 signed ovf", 2'd3, 64'h8000_0000_0000_0000, 64'd1);
    do_cmp("R2 aux borrow", 2'd3, 64'h20, 64'h01);
    check("R2 explicit ZF", flags[6], 0);
  endtask

  task automatic t_widths();
    do_cmp("R3 byte zero", 2'd0, 64'hFFFF_FF00, 64'h0000_1200);
    check("R3 byte ZF set", flags[6], 1);
    do_cmp("R3 byte ovf", 2'd0, 64'h80, 64'h01);
    check("R3 byte OF set", flags[11], 1);
    do_cmp("R3 word", 2'd1, 64'hABCD_0001, 64'h0000_0002);
    check("R3 word SF set", flags[7], 1);
    do_cmp("R3 dword", 2'd2, 64'h1_0000_0000, 64'h0);
  endtask

  task automatic t_imm();
    issue(2'd0, 2'd3, 64'hFFFF_FFFF_FFFF_FFFF, 64'd7, 1'b1, 32'h0000_00FF, 1'b1, 4'h0);
    check("R4 imm8 sign-extend", flags[6], 1);
    issue(2'd0, 2'd3, 64'hFFFF_FFFF_8000_0000, 64'd7, 1'b1, 32'h8000_0000, 1'b0, 4'h0);
    check("R4 imm32 sign-extend", flags[6], 1);
    issue(2'd0, 2'd3, 64'h0000_0000_8000_0000, 64'h0000_0000_8000_0000, 1'b1, 32'h8000_0000, 1'b0, 4'h0);
    exp_flags = ref_cmp(64'h8000_0000, 64'hFFFF_FFFF_8000_0000, 2'd3);
    check("R4 imm32 not equal", flags, exp_flags);
    issue(2'd0, 2'd1, 64'h0000_FFFE, 64'h0, 1'b1, 32'h0000_00FE, 1'b1, 4'h0);
    check("R4 imm8 at word", flags[6], 1);
    exp_flags = flags;
  endtask

  task automatic sweep(string tag);
    for (int c = 0; c < 16; c++) begin
      logic [63:0] v = 64'hDEAD_BEEF_0000_0000 | 64'(c);
      logic hit = ref_cond(exp_flags, 4'(c));
      issue(2'd1, 2'd3, 64'h0, v, 1'b0, 32'h0, 1'b0, 4'(c));
      check({"R6 ", tag}, wr_en, 64'(hit));
      if (hit) check("R7 data", wr_data, v);
      check("R8 flags kept", flags, exp_flags);
    end
  endtask

  task automatic t_conditions();
    do_cmp("R2 setup eq", 2'd3, 64'd5, 64'd5);           sweep("eq");
    do_cmp("R2 setup below", 2'd3, 64'd1, 64'd2);        sweep("below");
    do_cmp("R2 setup ovf", 2'd0, 64'h7F, 64'hFF);        sweep("ovf");
    do_cmp("R2 setup parity", 2'd3, 64'd13, 64'd10);     sweep("parity");
  endtask

  task automatic t_cmov_sizes();
    do_cmp("R2 setup", 2'd3, 64'd9, 64'd9);
    issue(2'd1, 2'd1, 64'h0, 64'h1234_5678_9ABC_DEF0, 1'b0, 32'h0, 1'b0, 4'h4);
    check("R7 word wr_en", wr_en, 1);
    check("R7 word data", wr_data, 64'h0000_0000_0000_DEF0);
    issue(2'd1, 2'd2, 64'h0, 64'h1234_5678_9ABC_DEF0, 1'b0, 32'h0, 1'b0, 4'h4);
    check("R7 dword data", wr_data, 64'h0000_0000_9ABC_DEF0);
    @(negedge clk);
    check("R7 single pulse", wr_en, 0);
    issue(2'd1, 2'd3, 64'h0, 64'h55, 1'b0, 32'h0, 1'b0, 4'h5);
    check("R8 false no write", wr_en, 0);
    issue(2'd1, 2'd0, 64'h0, 64'h55, 1'b0, 32'h0, 1'b0, 4'h4);
    check("R9 byte cmov no write", wr_en, 0);
    check("R9 byte cmov flags", flags, exp_flags);
  endtask

  task automatic t_cmc();
    do_cmp("R2 setup", 2'd3, 64'd1, 64'd2);
    issue(2'd2, 2'd3, 64'h0, 64'h0, 1'b0, 32'h0, 1'b0, 4'h0);
    check("R10 cmc clears CF", flags, exp_flags ^ 32'h1);
    issue(2'd2, 2'd3, 64'h0, 64'h0, 1'b0, 32'h0, 1'b0, 4'h0);
    check("R10 cmc restores CF", flags, exp_flags);
    check("R11 reserved", flags & ~32'h8D5, 32'h2);
  endtask

  task automatic t_idle();
    @(negedge clk);
    op_kind = 2'd0; src_a = 64'd1; src_b = 64'd99;
    @(negedge clk);
    check("R12 no valid flags", flags, exp_flags);
    issue(2'd3, 2'd3, 64'd1, 64'd99, 1'b0, 32'h0, 1'b0, 4'h0);
    check("R12 nop flags", flags, exp_flags);
    check("R12 nop wr_en", wr_en, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_cmp_basic();
    t_widths();
    t_imm();
    t_conditions();
    t_cmov_sizes();
    t_cmc();
    t_idle();
    finish_run();
  end
endmodule